// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent page translations. A requester offers a virtual address and a write flag. The block compares the page number against every valid entry at once. On a hit it answers in the same cycle with the physical address, which is the stored physical page number joined to the untouched in-page offset. It also reports the entry's use and modified status as they stood before this access. At the next clock edge it marks that entry as used, marks it modified if the access was a write, and makes it the most recent entry. On a miss it raises a miss flag in the same cycle, so the requester can cancel its side effects and replay the access once a translation has been supplied.

Translations arrive on a refill port. A refill whose page number is already cached rewrites that entry in place. Otherwise it takes the lowest-numbered empty slot, and only when every slot is full does it evict the least recently touched entry. Recency is held as a rank per entry. A one-cycle flush input drops every entry.

The lookup and refill ports use valid/ready rules. Refill has priority: while `rf_valid` is high, `lk_ready` is low and no lookup is accepted or answered. While `inv_all` is high, `rf_ready` is low and a refill offered in that cycle is not taken, but lookups are still accepted and answered as misses. A lookup is answered only in a cycle where `lk_valid && lk_ready`.

Top module: `tlb_fa`

## Requirements
- R1: An accepted lookup whose page number (bits [31:12] of the 32-bit virtual address) matches a valid entry raises `lk_hit` in that same cycle, with `lk_paddr[31:12]` equal to that entry's physical page number.
- R2: An accepted lookup that matches no valid entry raises `lk_miss` in that same cycle. In any cycle, `lk_hit` and `lk_miss` are never high together, and neither is high unless `lk_valid && lk_ready`.
- R3: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`.
- R4: On a hit, `lk_used` shows the entry's use bit before this access. Every hit sets that bit, and a refill of the entry clears it.
- R5: On a hit, `lk_dirty` shows the entry's modified bit before this access. A hit with `lk_write=1` sets the bit, a hit with `lk_write=0` leaves it unchanged, and a refill clears it.
- R6: A cycle with `inv_all` high invalidates every entry. A lookup accepted in that cycle, and any lookup after it until a new refill, reports a miss. `rf_ready` is low while `inv_all` is high.
- R7: A refill with a new page number fills an empty slot whenever one exists, so no valid translation is lost while the cache is not full.
- R8: When all entries are valid, a refill with a new page number replaces the entry whose last hit or refill is the oldest. Both hits and refills count as uses.
- R9: A refill whose page number matches a valid entry rewrites that entry (new physical page number, use and modified bits cleared) and evicts nothing.
- R10: After reset no entry is valid, so every lookup misses, and `lk_ready` and `rf_ready` are both high. While `rf_valid` is high, `lk_ready` is low and neither `lk_hit` nor `lk_miss` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Invalidate every entry at the next edge |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup accepted (low while a refill is offered) |
| lk_vaddr | input | 32 | Virtual address: page number [31:12], offset [11:0] |
| lk_write | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Accepted lookup found its page |
| lk_miss | output | 1 | Accepted lookup found no page |
| lk_paddr | output | 32 | Physical address, meaningful with `lk_hit` |
| lk_used | output | 1 | Use bit of the hit entry before this access |
| lk_dirty | output | 1 | Modified bit of the hit entry before this access |
| rf_valid | input | 1 | Refill offered |
| rf_ready | output | 1 | Refill accepted (low during `inv_all`) |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_ppn | input | 20 | Physical page number to install |

## Verification
Hit, miss, address and status are combinational in the lookup's own cycle. The bench drives each lookup on a falling edge and compares it one nanosecond later, popping the expected result that the driver queued. A hit's update to the use, modified and recency state, and a refill or flush, take effect at the next rising edge. They are therefore checked on the following lookup, at least one full cycle later. Victim choice is inferred at the ports, from which pages still hit after a refill of a known recency order. Ready and back-pressure levels are sampled in the cycle the refill or flush is held.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VPN_W_DEF = 20;
  localparam int unsigned TLB_PPN_W_DEF = 20;
  localparam int unsigned TLB_OFF_W_DEF = 12;
  localparam int unsigned TLB_DEPTH_DEF = 4;

  // where a refill lands
  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_REUSE = 2'd1,
    SLOT_FREE  = 2'd2,
    SLOT_EVICT = 2'd3
  } slot_src_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned DEPTH = tlb_pkg::TLB_DEPTH_DEF,
  parameter int unsigned VPNW  = tlb_pkg::TLB_VPN_W_DEF,
  parameter int unsigned PPNW  = tlb_pkg::TLB_PPN_W_DEF,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  // lookup search
  input  logic [VPNW-1:0]  q_vpn,
  output logic             q_hit,
  output logic [IDXW-1:0]  q_idx,
  output logic [PPNW-1:0]  q_ppn,
  output logic             q_used,
  output logic             q_dirty,
  // status update for a hit
  input  logic             touch_en,
  input  logic             touch_wr,
  input  logic [IDXW-1:0]  touch_idx,
  // refill search and write
  input  logic [VPNW-1:0]  r_vpn,
  output logic             r_hit,
  output logic [IDXW-1:0]  r_idx,
  input  logic             fill_en,
  input  logic [IDXW-1:0]  fill_idx,
  input  logic [PPNW-1:0]  fill_ppn,
  output logic [DEPTH-1:0] valid_vec
);
  typedef struct packed {
    logic            valid;
    logic            used;
    logic            dirty;
    logic [VPNW-1:0] vpn;
    logic [PPNW-1:0] ppn;
  } ent_t;

  ent_t ent_q [DEPTH];
  logic [DEPTH-1:0] q_match, r_match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign q_match[i]   = ent_q[i].valid && (ent_q[i].vpn == q_vpn);
    assign r_match[i]   = ent_q[i].valid && (ent_q[i].vpn == r_vpn);
    assign valid_vec[i] = ent_q[i].valid;
  end

  // page numbers are unique among valid entries, so at most one match
  always_comb begin
    q_idx = '0;
    r_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_match[i]) q_idx = IDXW'(i);
      if (r_match[i]) r_idx = IDXW'(i);
    end
  end

  assign q_hit   = |q_match;
  assign r_hit   = |r_match;
  assign q_ppn   = ent_q[q_idx].ppn;
  assign q_used  = ent_q[q_idx].used;
  assign q_dirty = ent_q[q_idx].dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush) begin
          ent_q[i].valid <= 1'b0;
        end else if (fill_en && (fill_idx == IDXW'(i))) begin
          ent_q[i].valid <= 1'b1;
          ent_q[i].used  <= 1'b0;
          ent_q[i].dirty <= 1'b0;
          ent_q[i].vpn   <= r_vpn;
          ent_q[i].ppn   <= fill_ppn;
        end else if (touch_en && (touch_idx == IDXW'(i))) begin
          ent_q[i].used <= 1'b1;
          if (touch_wr) ent_q[i].dirty <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
  parameter int unsigned DEPTH = tlb_pkg::TLB_DEPTH_DEF,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_en,
  input  logic [IDXW-1:0] touch_idx,
  output logic [IDXW-1:0] oldest_idx
);
  // rank 0 = most recent, DEPTH-1 = least recent; ranks form a permutation
  logic [IDXW-1:0] age_q [DEPTH];
  logic [IDXW-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= IDXW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (touch_idx == IDXW'(i))       age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (age_q[i] == IDXW'(DEPTH - 1)) oldest_idx = IDXW'(i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned DEPTH = tlb_pkg::TLB_DEPTH_DEF,
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             req,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic             reuse_hit,
  input  logic [IDXW-1:0]  reuse_idx,
  input  logic [IDXW-1:0]  oldest_idx,
  output logic [IDXW-1:0]  fill_idx
);
  import tlb_pkg::*;

  slot_src_e       src;
  logic            free_any;
  logic [IDXW-1:0] free_idx;

  // lowest-numbered empty slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    if (!req)           src = SLOT_NONE;
    else if (reuse_hit) src = SLOT_REUSE;
    else if (free_any)  src = SLOT_FREE;
    else                src = SLOT_EVICT;
  end

  always_comb begin
    unique case (src)
      SLOT_REUSE: fill_idx = reuse_idx;
      SLOT_FREE:  fill_idx = free_idx;
      SLOT_EVICT: fill_idx = oldest_idx;
      default:    fill_idx = '0;
    endcase
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int unsigned VPN_W = tlb_pkg::TLB_VPN_W_DEF,
  parameter int unsigned PPN_W = tlb_pkg::TLB_PPN_W_DEF,
  parameter int unsigned OFF_W = tlb_pkg::TLB_OFF_W_DEF,
  parameter int unsigned DEPTH = tlb_pkg::TLB_DEPTH_DEF,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_used,
  output logic             lk_dirty,
  input  logic             rf_valid,
  output logic             rf_ready,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn
);
  localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             q_hit, q_used, q_dirty, r_hit, fill_en, acc, age_touch;
  logic [IDXW-1:0]  q_idx, r_idx, fill_idx, oldest_idx, age_idx;
  logic [PPN_W-1:0] q_ppn;
  logic [DEPTH-1:0] valid_vec;

  // refill wins over lookup; flush wins over refill
  assign lk_ready = ~rf_valid;
  assign rf_ready = ~inv_all;
  assign acc      = lk_valid & lk_ready;
  assign fill_en  = rf_valid & rf_ready;

  assign lk_hit   = acc & q_hit & ~inv_all;
  assign lk_miss  = acc & ~lk_hit;
  assign lk_paddr = {q_ppn, lk_vaddr[OFF_W-1:0]};
  assign lk_used  = lk_hit & q_used;
  assign lk_dirty = lk_hit & q_dirty;

  assign age_touch = lk_hit | fill_en;
  assign age_idx   = fill_en ? fill_idx : q_idx;

  tlb_cam #(.DEPTH(DEPTH), .VPNW(VPN_W), .PPNW(PPN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (inv_all),
    .q_vpn     (lk_vaddr[VA_W-1:OFF_W]),
    .q_hit     (q_hit),
    .q_idx     (q_idx),
    .q_ppn     (q_ppn),
    .q_used    (q_used),
    .q_dirty   (q_dirty),
    .touch_en  (lk_hit),
    .touch_wr  (lk_write),
    .touch_idx (q_idx),
    .r_vpn     (rf_vpn),
    .r_hit     (r_hit),
    .r_idx     (r_idx),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_ppn  (rf_ppn),
    .valid_vec (valid_vec)
  );

  tlb_age #(.DEPTH(DEPTH)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (age_touch),
    .touch_idx  (age_idx),
    .oldest_idx (oldest_idx)
  );

  tlb_victim #(.DEPTH(DEPTH)) u_victim (
    .req        (fill_en),
    .valid_vec  (valid_vec),
    .reuse_hit  (r_hit),
    .reuse_idx  (r_idx),
    .oldest_idx (oldest_idx),
    .fill_idx   (fill_idx)
  );
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned VPN_W = tlb_pkg::TLB_VPN_W_DEF,
  parameter int unsigned PPN_W = tlb_pkg::TLB_PPN_W_DEF,
  parameter int unsigned OFF_W = tlb_pkg::TLB_OFF_W_DEF,
  parameter int unsigned DEPTH = tlb_pkg::TLB_DEPTH_DEF,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv_all,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_write,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             lk_used,
  input logic             lk_dirty,
  input logic             rf_valid,
  input logic             rf_ready,
  input logic [VPN_W-1:0] rf_vpn,
  input logic [PPN_W-1:0] rf_ppn
);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  a_r2_answer_when_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |-> (lk_hit || lk_miss));

  a_r2_miss_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_valid && lk_ready));

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  a_r4_used_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && $past(lk_hit) &&
     lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])) |-> lk_used);

  a_r5_dirty_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && $past(lk_hit && lk_write) &&
     lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W])) |-> lk_dirty);

  a_r6_flush_cycle_miss: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> (!lk_hit && !rf_ready));

  a_r6_flush_next_miss: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

  a_r10_refill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |-> (!lk_ready && !lk_hit && !lk_miss));
endmodule

bind tlb_fa tlb_fa_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit, lk_miss, lk_used, lk_dirty;
  logic [31:0] lk_paddr;
  logic        rf_valid = 1'b0;
  logic        rf_ready;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_ppn = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // scoreboard queues
  bit          sb_hit[$];
  logic [31:0] sb_pa[$];
  int          sb_used[$];
  int          sb_dirty[$];
  string       sb_req[$];

  always #2 clk = ~clk;

  tlb_fa dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_used(lk_used), .lk_dirty(lk_dirty),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn)
  );

  function automatic logic [31:0] va(input logic [19:0] pn, input logic [11:0] off);
    return {pn, off};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one lookup, optionally with a flush in the same cycle
  task automatic lookup(input logic [31:0] a, input bit wr, input bit flush,
                        input bit eh, input logic [31:0] epa,
                        input int eu, input int ed, input string req);
    @(negedge clk);
    sb_hit.push_back(eh); sb_pa.push_back(epa);
    sb_used.push_back(eu); sb_dirty.push_back(ed); sb_req.push_back(req);
    lk_valid = 1'b1; lk_vaddr = a; lk_write = wr; inv_all = flush;
    if (flush) begin
      #1 chk(rf_ready == 1'b0, req, "rf_ready during flush", 32'(rf_ready), 32'd0);
    end
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0; inv_all = 1'b0;
  endtask

  task automatic refill(input logic [19:0] pn, input logic [19:0] pp, input bit with_lk);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = pn; rf_ppn = pp;
    if (with_lk) begin
      lk_valid = 1'b1; lk_vaddr = va(pn, 12'h111);
    end
    #1;
    chk(lk_ready == 1'b0, "R10", "lk_ready during refill", 32'(lk_ready), 32'd0);
    chk(rf_ready == 1'b1, "R10", "rf_ready", 32'(rf_ready), 32'd1);
    if (with_lk) begin
      chk(!lk_hit && !lk_miss, "R10", "answer while blocked",
          {30'd0, lk_hit, lk_miss}, 32'd0);
    end
    @(negedge clk);
    rf_valid = 1'b0; lk_valid = 1'b0;
  endtask

  // monitor: compares accepted lookups 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (lk_valid && lk_ready) begin
        if (sb_hit.size() == 0) begin
          chk(1'b0, "R2", "unexpected answer", 32'(lk_hit), 32'd0);
        end else begin
          automatic bit          eh = sb_hit.pop_front();
          automatic logic [31:0] ep = sb_pa.pop_front();
          automatic int          eu = sb_used.pop_front();
          automatic int          ed = sb_dirty.pop_front();
          automatic string       rq = sb_req.pop_front();
          chk(lk_hit == eh, rq, "lk_hit", 32'(lk_hit), 32'(eh));
          chk(lk_miss == !eh, rq, "lk_miss", 32'(lk_miss), 32'(!eh));
          if (eh) begin
            chk(lk_paddr == ep, rq, "lk_paddr", lk_paddr, ep);
            if (eu >= 0) chk(lk_used == eu[0], rq, "lk_used", 32'(lk_used), 32'(eu));
            if (ed >= 0) chk(lk_dirty == ed[0], rq, "lk_dirty", 32'(lk_dirty), 32'(ed));
          end
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(lk_ready == 1'b1, "R10", "reset lk_ready", 32'(lk_ready), 32'd1);
    chk(rf_ready == 1'b1, "R10", "reset rf_ready", 32'(rf_ready), 32'd1);
    lookup(va(20'h00010, 12'h5A5), 0, 0, 0, '0, -1, -1, "R10");

    // R1 R3 R4 R5 on one entry
    refill(20'h00010, 20'h00AAA, 0);
    lookup(va(20'h00010, 12'h5A5), 0, 0, 1, 32'h00AAA5A5, 0, 0, "R1");
    lookup(va(20'h00010, 12'hFFF), 1, 0, 1, 32'h00AAAFFF, 1, 0, "R4");
    lookup(va(20'h00010, 12'h000), 0, 0, 1, 32'h00AAA000, 1, 1, "R5");

    // fill to capacity: recency D,C,B,A
    refill(20'h00020, 20'h00BBB, 0);
    refill(20'h00030, 20'h00CCC, 0);
    refill(20'h00040, 20'h00DDD, 0);
    lookup(va(20'h00010, 12'h123), 0, 0, 1, 32'h00AAA123, -1, -1, "R8");
    lookup(va(20'h00020, 12'h456), 0, 0, 1, 32'h00BBB456, 0, 0, "R4");
    // recency B,A,D,C -> C is evicted
    refill(20'h00050, 20'h00EEE, 0);
    lookup(va(20'h00030, 12'h001), 0, 0, 0, '0, -1, -1, "R8");
    lookup(va(20'h00010, 12'h002), 0, 0, 1, 32'h00AAA002, -1, -1, "R8");
    lookup(va(20'h00020, 12'h003), 0, 0, 1, 32'h00BBB003, -1, -1, "R8");
    lookup(va(20'h00040, 12'h004), 0, 0, 1, 32'h00DDD004, -1, -1, "R8");
    lookup(va(20'h00050, 12'h005), 0, 0, 1, 32'h00EEE005, -1, -1, "R8");
    // recency E,D,B,A -> A is evicted
    refill(20'h00060, 20'h000F0, 0);
    lookup(va(20'h00010, 12'h006), 0, 0, 0, '0, -1, -1, "R8");
    lookup(va(20'hFFFFF, 12'h007), 0, 0, 0, '0, -1, -1, "R2");

    // R9: rewrite B in place, nothing evicted
    refill(20'h00020, 20'h00123, 0);
    lookup(va(20'h00020, 12'h0AB), 0, 0, 1, 32'h001230AB, 0, 0, "R9");
    lookup(va(20'h00040, 12'h0CD), 0, 0, 1, 32'h00DDD0CD, -1, -1, "R9");
    lookup(va(20'h00050, 12'h0EF), 0, 0, 1, 32'h00EEE0EF, -1, -1, "R9");
    lookup(va(20'h00060, 12'h010), 0, 0, 1, 32'h000F0010, -1, -1, "R9");

    // R10: lookup offered while a refill is held
    refill(20'h00060, 20'h000F0, 1);

    // R6: flush with a lookup in the same cycle
    lookup(va(20'h00040, 12'h0CD), 0, 1, 0, '0, -1, -1, "R6");
    lookup(va(20'h00050, 12'h0EF), 0, 0, 0, '0, -1, -1, "R6");
    lookup(va(20'h00060, 12'h010), 0, 0, 0, '0, -1, -1, "R6");
    lookup(va(20'h00020, 12'h0AB), 0, 0, 0, '0, -1, -1, "R6");

    // R7: four fills into an empty cache keep all four
    refill(20'h00070, 20'h00777, 0);
    refill(20'h00080, 20'h00888, 0);
    refill(20'h00090, 20'h00999, 0);
    refill(20'h000A0, 20'h00ABC, 0);
    lookup(va(20'h00070, 12'h070), 0, 0, 1, 32'h00777070, 0, 0, "R7");
    lookup(va(20'h00080, 12'h080), 0, 0, 1, 32'h00888080, 0, 0, "R7");
    lookup(va(20'h00090, 12'h090), 0, 0, 1, 32'h00999090, 0, 0, "R7");
    lookup(va(20'h000A0, 12'h0A0), 0, 0, 1, 32'h00ABC0A0, 0, 0, "R7");
    // read hit leaves dirty clear
    lookup(va(20'h00070, 12'h071), 0, 0, 1, 32'h00777071, 1, 0, "R5");

    repeat (3) @(negedge clk);
    chk(sb_hit.size() == 0, "R2", "pending answers", 32'(sb_hit.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule